// File: doc/BRIEF.md
# MSI Node Cache Controller for a Directory Protocol

This block is the cache-side coherence agent of one processing node in a machine where coherence is kept by home directories rather than by a shared snooped bus. It holds a small direct-mapped cache. Each line has a tag, one data word and one of three states: modified, shared or invalid. Processor loads and stores that hit are served in the cycle they are presented. A miss stalls the processor. The controller then sends a read-miss or write-miss request to the node that owns the address, and completes the access once the reply has been installed. A read miss to a block owned by this node is served straight from local memory when the local directory reports that memory holds a valid copy.

The controller also answers commands from directories. A fetch caused by another node's read demotes a modified line to shared and forwards the data to both the home node and the requester. A fetch caused by another node's write forwards the data to the home node and drops the line. An invalidation drops the line and is always acknowledged. Evicting a modified line sends a writeback to its home node first. A shared line is dropped without any message.

Top module: `msi_node_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any address is a miss that raises a network request or a local fill.
- R2: A load miss to a remote home sends one message of type 1 (read miss) and a store miss sends type 2 (write miss). Each goes to the one-hot destination bit of the home node, which is address bits [7:6], and carries the full address. The processor is held off (ready low) until the reply is installed.
- R3: A reply of type 6 installs the block as shared and the pending load then returns the reply data. A reply of type 7 installs it as modified and the pending store then writes its data.
- R4: A store to a line held shared is a miss and sends a write-miss request (type 2) to the home node.
- R5: A load miss whose home is this node (NODE_ID) and for which the local dirty input is 0 sends no network message. It pulses the local-take output, returns the local memory word and leaves the line shared. If the dirty input is 1, a read miss goes over the network to this node's own home directory.
- R6: A read-fetch (type 8) for a line held modified sends data message type 4 with the line data to home and requester (source node) together, and leaves the line shared, so a later store misses.
- R7: A write-fetch (type 9) for a line held modified sends data message type 4 to the home node only and invalidates the line.
- R8: An invalidation (type 10) is always answered with an acknowledgement (type 5) to the source node. A matching line becomes invalid. An invalidation whose tag does not match, or which hits an invalid line, changes nothing.
- R9: A miss that displaces a modified line with a different tag first sends a writeback (type 3) with the old address and data to the old block's home. Displacing a shared line sends no message.
- R10: Loads that hit shared or modified lines, and stores that hit modified lines, complete in the same cycle with no network traffic.
- R11: While a directory message is presented on the input channel, the processor is not granted.
- R12: A fetch of either kind for a line that is not held modified is consumed with no message and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid_i | input | 1 | Processor request valid, held until ready |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Block address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Load data, valid with ready |
| out_valid_o | output | 1 | Outgoing message valid |
| out_ready_i | input | 1 | Network accepts outgoing message |
| out_type_o | output | 4 | Outgoing message type |
| out_dest_o | output | NODES | One-hot (or two-hot) destination mask |
| out_addr_o | output | ADDR_W | Message address |
| out_data_o | output | DATA_W | Message data |
| in_valid_i | input | 1 | Incoming message valid |
| in_ready_o | output | 1 | Incoming message consumed |
| in_type_i | input | 4 | Incoming message type |
| in_src_i | input | log2(NODES) | Node that originated the message or request |
| in_addr_i | input | ADDR_W | Incoming message address |
| in_data_i | input | DATA_W | Reply data |
| lm_addr_o | output | ADDR_W | Address presented to local memory/directory |
| lm_dirty_i | input | 1 | Local directory reports memory copy stale |
| lm_rdata_i | input | DATA_W | Local memory word at lm_addr_o |
| lm_take_o | output | 1 | Local fill used; directory records this node as sharer |

## Verification
The bound checker covers the rules that hold on every cycle. A grant never overlaps an incoming message. Every accepted invalidation yields an acknowledgement to its source. Forwarded data always includes the home node. Writebacks have exactly one destination. Local fills never coincide with network traffic. A store grant followed by a load of the same address returns the stored word. State-dependent outcomes can only be shown by the bench's scenarios, which compare message sequences and load data against a reference model of the cache. These outcomes are demotion by read-fetch, silent loss of shared lines, writeback ordering before a refill, untouched lines after a mismatched invalidation, and the local-memory shortcut.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } line_st_e;

  typedef enum logic [3:0] {
    MT_NONE     = 4'd0,
    MT_RD_MISS  = 4'd1,
    MT_WR_MISS  = 4'd2,
    MT_WBACK    = 4'd3,
    MT_FWD_DATA = 4'd4,
    MT_INV_ACK  = 4'd5,
    MT_RD_REPLY = 4'd6,
    MT_WR_REPLY = 4'd7,
    MT_FETCH_RD = 4'd8,
    MT_FETCH_WR = 4'd9,
    MT_INVAL    = 4'd10
  } msg_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_EVICT = 2'd1,
    FS_ISSUE = 2'd2,
    FS_WAIT  = 2'd3
  } miss_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_state,
  input  logic              wr_fill,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_st_e          ra_state,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_st_e          rb_state,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data
);
  line_st_e          st_q [SETS];
  line_st_e          st_d [SETS];
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  always_comb begin
    st_d = st_q;
    if (wr_en) st_d[wr_idx] = wr_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LN_I;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_fill) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assign ra_state = st_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_data  = dat_q[ra_idx];
  assign rb_state = st_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_data  = dat_q[rb_idx];
endmodule

// File: rtl/msi_dir_responder.sv
module msi_dir_responder
  import msi_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int NODE_W = 2,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                    in_valid,
  input  logic [3:0]              in_type,
  input  logic [NODE_W-1:0]       in_src,
  input  logic [ADDR_W-1:0]       in_addr,
  input  line_st_e                ln_state,
  input  logic [ADDR_W-IDX_W-1:0] ln_tag,
  input  logic [DATA_W-1:0]       ln_data,
  input  logic                    out_ready,
  output logic                    in_ready,
  output logic                    rsp_valid,
  output logic [3:0]              rsp_type,
  output logic [NODES-1:0]        rsp_dest,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    upd_en,
  output line_st_e                upd_state
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

  logic             tag_hit, own_m, need, upd;
  logic [NODES-1:0] home_oh, src_oh;

  assign tag_hit = (ln_state != LN_I) && (ln_tag == in_addr[ADDR_W-1 -: TAG_W]);
  assign own_m   = tag_hit && (ln_state == LN_M);
  assign home_oh = ONE << in_addr[ADDR_W-1 -: NODE_W];
  assign src_oh  = ONE << in_src;

  always_comb begin
    need      = 1'b0;
    upd       = 1'b0;
    upd_state = LN_I;
    rsp_type  = MT_NONE;
    rsp_dest  = '0;
    rsp_data  = ln_data;
    case (msg_e'(in_type))
      MT_FETCH_RD: begin
        need      = own_m;
        upd       = own_m;
        upd_state = LN_S;
        rsp_type  = MT_FWD_DATA;
        rsp_dest  = home_oh | src_oh;
      end
      MT_FETCH_WR: begin
        need      = own_m;
        upd       = own_m;
        upd_state = LN_I;
        rsp_type  = MT_FWD_DATA;
        rsp_dest  = home_oh;
      end
      MT_INVAL: begin
        need      = 1'b1;
        upd       = tag_hit;
        upd_state = LN_I;
        rsp_type  = MT_INV_ACK;
        rsp_dest  = src_oh;
        rsp_data  = '0;
      end
      default: ;
    endcase
  end

  assign in_ready  = need ? out_ready : 1'b1;
  assign rsp_valid = in_valid && need;
  assign upd_en    = in_valid && in_ready && upd;
endmodule

// File: rtl/msi_miss_fsm.sv
module msi_miss_fsm
  import msi_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int NODE_ID = 0,
  parameter int NODE_W  = 2,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_hit,
  input  line_st_e                va_state,
  input  logic [ADDR_W-IDX_W-1:0] va_tag,
  input  logic [DATA_W-1:0]       va_data,
  input  logic                    in_valid,
  input  logic [3:0]              in_type,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [DATA_W-1:0]       in_data,
  input  logic                    lm_dirty,
  input  logic [DATA_W-1:0]       lm_rdata,
  input  logic                    net_ready,
  output logic                    busy,
  output logic [ADDR_W-1:0]       req_addr,
  output logic                    net_valid,
  output logic [3:0]              net_type,
  output logic [NODES-1:0]        net_dest,
  output logic [ADDR_W-1:0]       net_addr,
  output logic [DATA_W-1:0]       net_data,
  output logic                    fill_en,
  output line_st_e                fill_state,
  output logic                    fill_td,
  output logic [DATA_W-1:0]       fill_data,
  output logic                    lm_take
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [NODES-1:0] ONE = {{(NODES-1){1'b0}}, 1'b1};

  miss_st_e          fsm_q, fsm_d;
  logic [ADDR_W-1:0] req_q, req_d;
  logic              we_q, we_d;
  logic              cap_en;
  logic [ADDR_W-1:0] vic_addr;
  logic              req_local, vic_dirty, reply_ok;

  assign vic_addr  = {va_tag, req_q[IDX_W-1:0]};
  assign req_local = (req_q[ADDR_W-1 -: NODE_W] == NODE_W'(NODE_ID));
  assign vic_dirty = (va_state == LN_M) && (va_tag != req_q[ADDR_W-1 -: TAG_W]);
  assign reply_ok  = in_valid && (in_addr == req_q) &&
                     ((msg_e'(in_type) == MT_RD_REPLY) || (msg_e'(in_type) == MT_WR_REPLY));

  always_comb begin
    fsm_d      = fsm_q;
    req_d      = req_q;
    we_d       = we_q;
    cap_en     = 1'b0;
    net_valid  = 1'b0;
    net_type   = MT_NONE;
    net_dest   = '0;
    net_addr   = req_q;
    net_data   = '0;
    fill_en    = 1'b0;
    fill_state = LN_I;
    fill_td    = 1'b0;
    fill_data  = in_data;
    lm_take    = 1'b0;
    case (fsm_q)
      FS_IDLE: begin
        if (cpu_valid && !cpu_hit && !in_valid) begin
          cap_en = 1'b1;
          req_d  = cpu_addr;
          we_d   = cpu_we;
          fsm_d  = ((va_state == LN_M) && (va_tag != cpu_addr[ADDR_W-1 -: TAG_W]))
                   ? FS_EVICT : FS_ISSUE;
        end
      end
      FS_EVICT: begin
        if (!in_valid) begin
          if (vic_dirty) begin
            net_valid = 1'b1;
            net_type  = MT_WBACK;
            net_dest  = ONE << vic_addr[ADDR_W-1 -: NODE_W];
            net_addr  = vic_addr;
            net_data  = va_data;
            if (net_ready) begin
              fill_en = 1'b1;
              fsm_d   = FS_ISSUE;
            end
          end else begin
            fsm_d = FS_ISSUE;
          end
        end
      end
      FS_ISSUE: begin
        if (!in_valid) begin
          if (req_local && !we_q && !lm_dirty) begin
            lm_take    = 1'b1;
            fill_en    = 1'b1;
            fill_td    = 1'b1;
            fill_state = LN_S;
            fill_data  = lm_rdata;
            fsm_d      = FS_IDLE;
          end else begin
            net_valid = 1'b1;
            net_type  = we_q ? MT_WR_MISS : MT_RD_MISS;
            net_dest  = ONE << req_q[ADDR_W-1 -: NODE_W];
            if (net_ready) fsm_d = FS_WAIT;
          end
        end
      end
      FS_WAIT: begin
        if (reply_ok) begin
          fill_en    = 1'b1;
          fill_td    = 1'b1;
          fill_state = (msg_e'(in_type) == MT_WR_REPLY) ? LN_M : LN_S;
          fsm_d      = FS_IDLE;
        end
      end
      default: fsm_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q <= FS_IDLE;
      req_q <= '0;
      we_q  <= 1'b0;
    end else begin
      fsm_q <= fsm_d;
      if (cap_en) begin
        req_q <= req_d;
        we_q  <= we_d;
      end
    end
  end

  assign busy     = (fsm_q != FS_IDLE);
  assign req_addr = req_q;
endmodule

// File: rtl/msi_node_ctrl.sv
module msi_node_ctrl
  import msi_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int NODE_ID = 0,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int SETS    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_valid_i,
  input  logic                       cpu_we_i,
  input  logic [ADDR_W-1:0]          cpu_addr_i,
  input  logic [DATA_W-1:0]          cpu_wdata_i,
  output logic                       cpu_ready_o,
  output logic [DATA_W-1:0]          cpu_rdata_o,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic [3:0]                 out_type_o,
  output logic [NODES-1:0]           out_dest_o,
  output logic [ADDR_W-1:0]          out_addr_o,
  output logic [DATA_W-1:0]          out_data_o,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [3:0]                 in_type_i,
  input  logic [$clog2(NODES)-1:0]   in_src_i,
  input  logic [ADDR_W-1:0]          in_addr_i,
  input  logic [DATA_W-1:0]          in_data_i,
  output logic [ADDR_W-1:0]          lm_addr_o,
  input  logic                       lm_dirty_i,
  input  logic [DATA_W-1:0]          lm_rdata_i,
  output logic                       lm_take_o
);
  localparam int NODE_W = $clog2(NODES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W;

  line_st_e          ra_state, rb_state, wr_state, upd_state, fill_state;
  logic [TAG_W-1:0]  ra_tag, rb_tag, wr_tag;
  logic [DATA_W-1:0] ra_data, rb_data, wr_data, fill_data, rsp_data, net_data;
  logic [IDX_W-1:0]  ra_idx, wr_idx;
  logic              wr_en, wr_fill;
  logic              cpu_hit, store_go, busy;
  logic [ADDR_W-1:0] req_addr, net_addr;
  logic              rsp_valid, upd_en, net_valid, fill_en, fill_td;
  logic [3:0]        rsp_type, net_type;
  logic [NODES-1:0]  rsp_dest, net_dest;

  assign ra_idx  = busy ? req_addr[IDX_W-1:0] : cpu_addr_i[IDX_W-1:0];
  assign cpu_hit = (ra_state != LN_I) && (ra_tag == cpu_addr_i[ADDR_W-1 -: TAG_W]) &&
                   (!cpu_we_i || (ra_state == LN_M));
  assign cpu_ready_o = cpu_valid_i && cpu_hit && !busy && !in_valid_i;
  assign cpu_rdata_o = ra_data;
  assign store_go    = cpu_ready_o && cpu_we_i;

  msi_line_store #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) store_u (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state), .wr_fill(wr_fill),
    .wr_tag(wr_tag), .wr_data(wr_data),
    .ra_idx(ra_idx), .ra_state(ra_state), .ra_tag(ra_tag), .ra_data(ra_data),
    .rb_idx(in_addr_i[IDX_W-1:0]), .rb_state(rb_state), .rb_tag(rb_tag), .rb_data(rb_data)
  );

  msi_dir_responder #(
    .NODES(NODES), .NODE_W(NODE_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) resp_u (
    .in_valid(in_valid_i), .in_type(in_type_i), .in_src(in_src_i), .in_addr(in_addr_i),
    .ln_state(rb_state), .ln_tag(rb_tag), .ln_data(rb_data), .out_ready(out_ready_i),
    .in_ready(in_ready_o), .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_dest(rsp_dest),
    .rsp_data(rsp_data), .upd_en(upd_en), .upd_state(upd_state)
  );

  msi_miss_fsm #(
    .NODES(NODES), .NODE_ID(NODE_ID), .NODE_W(NODE_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) miss_u (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid_i), .cpu_we(cpu_we_i), .cpu_addr(cpu_addr_i), .cpu_hit(cpu_hit),
    .va_state(ra_state), .va_tag(ra_tag), .va_data(ra_data),
    .in_valid(in_valid_i), .in_type(in_type_i), .in_addr(in_addr_i), .in_data(in_data_i),
    .lm_dirty(lm_dirty_i), .lm_rdata(lm_rdata_i), .net_ready(out_ready_i),
    .busy(busy), .req_addr(req_addr),
    .net_valid(net_valid), .net_type(net_type), .net_dest(net_dest),
    .net_addr(net_addr), .net_data(net_data),
    .fill_en(fill_en), .fill_state(fill_state), .fill_td(fill_td),
    .fill_data(fill_data), .lm_take(lm_take_o)
  );

  // One write port: directory commands, then miss engine, then store hits.
  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = cpu_addr_i[IDX_W-1:0];
    wr_state = LN_M;
    wr_fill  = 1'b0;
    wr_tag   = cpu_addr_i[ADDR_W-1 -: TAG_W];
    wr_data  = cpu_wdata_i;
    if (upd_en) begin
      wr_en    = 1'b1;
      wr_idx   = in_addr_i[IDX_W-1:0];
      wr_state = upd_state;
    end else if (fill_en) begin
      wr_en    = 1'b1;
      wr_idx   = req_addr[IDX_W-1:0];
      wr_state = fill_state;
      wr_fill  = fill_td;
      wr_tag   = req_addr[ADDR_W-1 -: TAG_W];
      wr_data  = fill_data;
    end else if (store_go) begin
      wr_en   = 1'b1;
      wr_fill = 1'b1;
    end
  end

  // Directory responses own the output channel whenever they are present.
  assign out_valid_o = rsp_valid || net_valid;
  assign out_type_o  = rsp_valid ? rsp_type : net_type;
  assign out_dest_o  = rsp_valid ? rsp_dest : net_dest;
  assign out_addr_o  = rsp_valid ? in_addr_i : net_addr;
  assign out_data_o  = rsp_valid ? rsp_data : net_data;
  assign lm_addr_o   = req_addr;
endmodule

// File: rtl/msi_node_ctrl_chk.sv
module msi_node_ctrl_chk #(
  parameter int NODES   = 4,
  parameter int NODE_ID = 0,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cpu_valid_i,
  input logic                     cpu_we_i,
  input logic [ADDR_W-1:0]        cpu_addr_i,
  input logic [DATA_W-1:0]        cpu_wdata_i,
  input logic                     cpu_ready_o,
  input logic [DATA_W-1:0]        cpu_rdata_o,
  input logic                     out_valid_o,
  input logic [3:0]               out_type_o,
  input logic [NODES-1:0]         out_dest_o,
  input logic [ADDR_W-1:0]        out_addr_o,
  input logic                     in_valid_i,
  input logic                     in_ready_o,
  input logic [3:0]               in_type_i,
  input logic [$clog2(NODES)-1:0] in_src_i,
  input logic [ADDR_W-1:0]        lm_addr_o,
  input logic                     lm_take_o
);
  localparam int NODE_W = $clog2(NODES);

  AST_GRANT_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready_o |-> (cpu_valid_i && !in_valid_i)); // R11

  AST_INVAL_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && in_type_i == 4'd10) |->
    (out_valid_o && out_type_o == 4'd5 && out_dest_o == (NODES'(1) << in_src_i))); // R8

  AST_FWD_HAS_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_type_o == 4'd4) |-> out_dest_o[out_addr_o[ADDR_W-1 -: NODE_W]]); // R6

  AST_WBACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_type_o == 4'd3) |->
    ($countones(out_dest_o) == 1 && out_dest_o[out_addr_o[ADDR_W-1 -: NODE_W]])); // R9

  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lm_take_o |-> (!out_valid_o && lm_addr_o[ADDR_W-1 -: NODE_W] == NODE_W'(NODE_ID))); // R5

  AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready_o && cpu_we_i) |=>
    ((cpu_valid_i && !cpu_we_i && !in_valid_i && cpu_addr_i == $past(cpu_addr_i)) ->
     (cpu_ready_o && cpu_rdata_o == $past(cpu_wdata_i)))); // R10
endmodule

bind msi_node_ctrl msi_node_ctrl_chk #(
  .NODES(NODES), .NODE_ID(NODE_ID), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_u (
  .clk(clk), .rst_n(rst_n),
  .cpu_valid_i(cpu_valid_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
  .cpu_wdata_i(cpu_wdata_i), .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
  .out_valid_o(out_valid_o), .out_type_o(out_type_o), .out_dest_o(out_dest_o),
  .out_addr_o(out_addr_o), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_type_i(in_type_i), .in_src_i(in_src_i), .lm_addr_o(lm_addr_o), .lm_take_o(lm_take_o)
);

// File: tb/msi_node_ctrl_tb.sv
`timescale 1ns/1ps
module msi_node_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_we, cpu_ready;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        out_valid, out_ready;
  logic [3:0]  out_type;
  logic [3:0]  out_dest;
  logic [7:0]  out_addr;
  logic [15:0] out_data;
  logic        in_valid, in_ready;
  logic [3:0]  in_type;
  logic [1:0]  in_src;
  logic [7:0]  in_addr;
  logic [15:0] in_data;
  logic [7:0]  lm_addr;
  logic        lm_dirty, lm_take;
  logic [15:0] lm_rdata;

  always #2 clk = ~clk;

  assign lm_rdata = {lm_addr, ~lm_addr};

  msi_node_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_type_o(out_type),
    .out_dest_o(out_dest), .out_addr_o(out_addr), .out_data_o(out_data),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_type_i(in_type), .in_src_i(in_src),
    .in_addr_i(in_addr), .in_data_i(in_data),
    .lm_addr_o(lm_addr), .lm_dirty_i(lm_dirty), .lm_rdata_i(lm_rdata), .lm_take_o(lm_take)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model: 0 = I, 1 = S, 2 = M
  logic [1:0]  m_st [8];
  logic [4:0]  m_tag [8];
  logic [15:0] m_dat [8];

  logic [3:0]  lg_t [8];
  logic [3:0]  lg_d [8];
  logic [7:0]  lg_a [8];
  logic [15:0] lg_v [8];
  int          lg_n;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic log_out();
    if (out_valid && lg_n < 8) begin
      lg_t[lg_n] = out_type; lg_d[lg_n] = out_dest;
      lg_a[lg_n] = out_addr; lg_v[lg_n] = out_data;
      lg_n++;
    end
  endtask

  function automatic logic [15:0] lmv(input logic [7:0] a);
    return {a, ~a};
  endfunction

  task automatic cpu_do(input logic we, input logic [7:0] a, input logic [15:0] wd,
                        input logic dirty, input logic [15:0] rep,
                        output logic [15:0] rd, output int cyc, output bit done);
    int pend = 0;
    lg_n = 0; done = 0; cyc = 0; rd = '0;
    @(negedge clk);
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; lm_dirty = dirty;
    for (int k = 0; k < 30 && !done; k++) begin
      if (k > 0) begin
        @(negedge clk);
        if (pend == 1) begin
          in_valid = 1; in_type = we ? 4'd7 : 4'd6; in_addr = a; in_data = rep;
          in_src = a[7:6]; pend = 2;
        end else begin
          in_valid = 0;
        end
      end
      #1;
      log_out();
      if (out_valid && pend == 0 && (out_type == 4'd1 || out_type == 4'd2)) pend = 1;
      if (cpu_ready) begin rd = cpu_rdata; done = 1; cyc = k; end
    end
    @(negedge clk);
    cpu_valid = 0; in_valid = 0;
  endtask

  task automatic check_op(input logic we, input logic [7:0] a, input logic [15:0] wd,
                          input logic dirty, input string rq);
    logic [2:0]  ix = a[2:0];
    logic [4:0]  tg = a[7:3];
    logic [3:0]  et [2];
    logic [3:0]  ed [2];
    logic [7:0]  ea [2];
    logic [15:0] ev [2];
    bit          ec [2];
    int          en = 0, cyc;
    bit          hit, sc, done;
    logic [15:0] rep = 16'($urandom), rd, erd;
    hit = (m_st[ix] != 0) && (m_tag[ix] == tg) && (!we || m_st[ix] == 2);
    sc  = (a[7:6] == 2'd0) && !we && !dirty;
    if (!hit) begin
      if (m_st[ix] == 2 && m_tag[ix] != tg) begin
        et[en] = 4'd3; ed[en] = 4'd1 << m_tag[ix][4:3]; ea[en] = {m_tag[ix], ix};
        ev[en] = m_dat[ix]; ec[en] = 1; en++;
      end
      if (!sc) begin
        et[en] = we ? 4'd2 : 4'd1; ed[en] = 4'd1 << a[7:6]; ea[en] = a;
        ev[en] = '0; ec[en] = 0; en++;
      end
    end
    cpu_do(we, a, wd, dirty, rep, rd, cyc, done);
    chk(done, {rq, " completion"}, 32'(done), 1);
    chk(lg_n == en, {rq, " message count"}, lg_n, en);
    for (int i = 0; i < en && i < lg_n; i++) begin
      chk(lg_t[i] == et[i], {rq, " type"}, lg_t[i], et[i]);
      chk(lg_d[i] == ed[i], {rq, " dest"}, lg_d[i], ed[i]);
      chk(lg_a[i] == ea[i], {rq, " addr"}, lg_a[i], ea[i]);
      if (ec[i]) chk(lg_v[i] == ev[i], {rq, " data"}, lg_v[i], ev[i]);
    end
    if (hit) chk(cyc == 0, "R10 hit latency", cyc, 0);
    else     chk(cyc > 0, "R2 miss stalls", cyc, 1);
    if (!we) begin
      erd = hit ? m_dat[ix] : (sc ? lmv(a) : rep);
      chk(rd == erd, {rq, " load data"}, rd, erd);
    end
    if (!hit) begin
      m_tag[ix] = tg;
      m_st[ix]  = we ? 2'd2 : 2'd1;
      m_dat[ix] = sc ? lmv(a) : rep;
    end
    if (we) m_dat[ix] = wd;
  endtask

  task automatic dir_msg(input logic [3:0] t, input logic [1:0] src, input logic [7:0] a,
                         input string rq);
    logic [2:0] ix = a[2:0];
    bit         hit = (m_st[ix] != 0) && (m_tag[ix] == a[7:3]);
    bit         own = hit && m_st[ix] == 2;
    int         en = 0;
    logic [3:0] ed = '0, et = '0;
    logic [15:0] ev = m_dat[ix];
    if (t == 4'd8 && own)  begin en = 1; et = 4'd4; ed = (4'd1 << a[7:6]) | (4'd1 << src); end
    if (t == 4'd9 && own)  begin en = 1; et = 4'd4; ed = 4'd1 << a[7:6]; end
    if (t == 4'd10)        begin en = 1; et = 4'd5; ed = 4'd1 << src; end
    lg_n = 0;
    @(negedge clk);
    in_valid = 1; in_type = t; in_src = src; in_addr = a; in_data = 16'hDEAD;
    #1;
    log_out();
    chk(in_ready == 1'b1, {rq, " consumed"}, in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    chk(lg_n == en, {rq, " response count"}, lg_n, en);
    if (en == 1 && lg_n == 1) begin
      chk(lg_t[0] == et, {rq, " response type"}, lg_t[0], et);
      chk(lg_d[0] == ed, {rq, " response dest"}, lg_d[0], ed);
      chk(lg_a[0] == a, {rq, " response addr"}, lg_a[0], a);
      if (et == 4'd4) chk(lg_v[0] == ev, {rq, " response data"}, lg_v[0], ev);
    end
    if (t == 4'd8 && own) m_st[ix] = 1;
    if (t == 4'd9 && own) m_st[ix] = 0;
    if (t == 4'd10 && hit) m_st[ix] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cpu_valid = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    out_ready = 1; in_valid = 0; in_type = 0; in_src = 0; in_addr = 0; in_data = 0;
    lm_dirty = 0;
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(out_valid == 0, "R1 reset quiet", out_valid, 0);
    chk(cpu_ready == 0, "R1 reset no grant", cpu_ready, 0);

    check_op(0, 8'h45, 0, 0, "R1 R2 R3 first load miss");
    check_op(0, 8'h45, 0, 0, "R10 load hit S");
    check_op(1, 8'h45, 16'h1111, 0, "R4 upgrade store");
    check_op(1, 8'h45, 16'h2222, 0, "R10 store hit M");
    dir_msg(4'd8, 2'd2, 8'h45, "R6 read fetch");
    check_op(0, 8'h45, 0, 0, "R6 demoted line still readable");
    check_op(1, 8'h45, 16'h3333, 0, "R6 store after demotion misses");
    dir_msg(4'd10, 2'd1, 8'h85, "R8 mismatched inval");
    check_op(0, 8'h45, 0, 0, "R8 line untouched");
    dir_msg(4'd10, 2'd1, 8'h45, "R8 matching inval");
    check_op(0, 8'h45, 0, 0, "R8 load after inval misses");
    dir_msg(4'd10, 2'd3, 8'h33, "R8 inval on invalid line");
    check_op(1, 8'h85, 16'h4444, 0, "R9 shared victim silent");
    check_op(0, 8'h45, 0, 0, "R9 modified victim writeback");
    check_op(0, 8'h0D, 0, 0, "R5 local fill");
    check_op(0, 8'h0D, 0, 0, "R5 local line hits");
    check_op(0, 8'h16, 0, 1, "R5 local dirty goes to network");
    dir_msg(4'd8, 2'd1, 8'h0D, "R12 fetch on shared");
    dir_msg(4'd9, 2'd1, 8'h0D, "R12 write fetch on shared");
    check_op(0, 8'h0D, 0, 0, "R12 shared line unchanged");
    check_op(1, 8'hEA, 16'h5555, 0, "R2 store miss");
    dir_msg(4'd9, 2'd1, 8'hEA, "R7 write fetch");
    check_op(0, 8'hEA, 0, 0, "R7 line invalid after write fetch");

    // R11: a directory message blocks a grant for a hitting load
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_addr = 8'h0D;
    in_valid = 1; in_type = 4'd10; in_src = 2'd2; in_addr = 8'h40;
    #1;
    chk(cpu_ready == 0, "R11 grant withheld", cpu_ready, 0);
    chk(out_valid && out_type == 4'd5, "R11 R8 ack during block", out_type, 5);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(cpu_ready == 1, "R11 grant after message", cpu_ready, 1);
    @(negedge clk);
    cpu_valid = 0;

    for (int n = 0; n < 400; n++) begin
      logic [7:0] a = 8'($urandom);
      int sel = $urandom_range(0, 9);
      if (sel < 7) check_op(1'($urandom), a, 16'($urandom), 1'($urandom), "R2 R3 R9 random op");
      else if (sel == 7) dir_msg(4'd8, 2'($urandom), a, "R6 R12 random fetch");
      else if (sel == 8) dir_msg(4'd9, 2'($urandom), a, "R7 R12 random fetch");
      else dir_msg(4'd10, 2'($urandom), a, "R8 random inval");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule